// File: doc/BRIEF.md
# Descriptor Ring Transmit Queue Engine

This block serves one transmit endpoint. It follows a chain of 16-byte descriptors in memory and sends the data buffer each one names into an outgoing packet stream, one 32-bit beat at a time. Software fills in a descriptor and sets the ownership flag in its control word last. The engine fetches the descriptor and moves the data. It then writes the length word back and returns ownership by clearing that flag, which is its final write. The engine also signals completion when software asked for it.

Software steers the engine with three one-cycle commands: start, stop and resume. It reads an active flag and the pointer to the descriptor in use. When the engine meets a descriptor it does not own, or a fault, it parks and holds the pointer on that descriptor, so software can repair it and resume. A descriptor that carries both the skip flag and the ownership flag is handed back at once, with no data moved. A transmit descriptor of zero length is refused with a length-fault event, so that software can send the empty packet by other means. Memory is a single synchronous port whose read data arrives one cycle after the request.

Descriptor layout: word 0 is control, word 1 is the low 32 bits of the next-descriptor address, word 2 is the low 32 bits of the buffer address, and word 3 holds the byte length in its low bits. Control bit 0 is the ownership flag, bit 2 is skip and bit 7 asks for a completion event.

Top module: `dq_ring_engine`

## Requirements
- R1: After reset the queue is inactive. `mem_req`, `tx_valid`, `evt_done`, `evt_lenerr` and `evt_cserr` are all low.
- R2: A `cmd_start` while inactive copies `start_addr` into `cur_ptr` and raises `q_active` one cycle later. A `cmd_start` while active changes nothing.
- R3: The engine reads the four words at `cur_ptr`, `cur_ptr`+4, +8 and +12. An owned descriptor of length L bytes then yields ceil(L/4) beats read from consecutive words starting at the buffer address. `tx_last` is high only on the final beat, and a beat holds its data until `tx_ready`.
- R4: A descriptor with control bit 0 clear parks the engine. `q_active` stays high, `cur_ptr` is held, there are no memory writes, and `cmd_resume` fetches the same descriptor again.
- R5: A completed descriptor gets two writes, in this order: word 3, with the length field written back and all other bits kept, then word 0, with bit 0 cleared and all other bits kept.
- R6: `evt_done` pulses for one cycle, in the cycle right after the word-0 write, and only when control bit 7 is set.
- R7: An owned, non-skipped descriptor whose length is zero raises `evt_lenerr` for one cycle and halts the engine. No beat is sent, no write is made and `cur_ptr` is held.
- R8: A descriptor with control bits 0 and 2 both set sends no beats. Its word 0 is written with bit 0 cleared, and the engine moves on to the next descriptor.
- R9: A pulse on `link_cserr` during a transfer ends that transfer after the beat in flight. `evt_cserr` pulses, the engine halts with `cur_ptr` held, and no writeback is made. A later resume sends the descriptor again from its first beat.
- R10: `cmd_stop` clears `q_active` once the beat in flight has finished, and no writeback is made. While inactive the engine makes no memory request, and `cmd_resume` has no effect.
- R11: `EXT_LAYOUT`=0 takes the length from word 3 bits [15:0], and bits [35:32] of the next and buffer addresses from control bits [23:20] and [19:16]. `EXT_LAYOUT`=1 takes the length from bits [19:0] and the two address nibbles from control bits [31:28] and [27:24].
- R12: After a descriptor completes or is skipped, `cur_ptr` becomes its next-descriptor address, with the high nibble taken from the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| start_addr | input | AW | Address of the first descriptor |
| q_active | output | 1 | Queue active flag |
| cur_ptr | output | AW | Address of the descriptor in use |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| tx_data | output | 32 | Outgoing beat data |
| tx_valid | output | 1 | Outgoing beat valid |
| tx_ready | input | 1 | Sink accepts the beat |
| tx_last | output | 1 | Final beat of a descriptor |
| link_cserr | input | 1 | Checksum fault reported by the link side |
| evt_done | output | 1 | Descriptor completion event |
| evt_lenerr | output | 1 | Zero-length fault event |
| evt_cserr | output | 1 | Checksum fault halt event |

## Verification
The bench builds the engine with `EXT_LAYOUT`=1 and `AW`=36, so the control word's upper two nibbles carry address bits [35:32]. A next pointer with a nonzero nibble shows in `cur_ptr` while the small bench memory aliases it onto a real descriptor. A buffer nibble of 2 shows on the memory address bus during that descriptor's reads. Because the length field is 20 bits wide, a flag at word 3 bit 29 sits above it and must survive the writeback. The sink's ready line can be held low, which lets checksum faults and stops land at a known beat, so the number of beats sent before a halt is exact.

// File: rtl/dqe_pkg.sv
package dqe_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned OWN_BIT  = 0;
   localparam int unsigned SKIP_BIT = 2;
   localparam int unsigned IRQ_BIT  = 7;

   typedef enum logic [3:0] {
      ST_OFF, ST_FREQ, ST_FCAP, ST_EVAL, ST_MOVE,
      ST_WB_LEN, ST_WB_CTL, ST_NEXT, ST_PARK, ST_HALT
   } eng_state_e;

   typedef enum logic [1:0] {
      MV_IDLE, MV_RD, MV_CAP, MV_PUSH
   } mv_state_e;

   function automatic int unsigned len_width(int unsigned ext);
      return (ext != 0) ? 20 : 16;
   endfunction
endpackage

// File: rtl/dqe_desc_view.sv
module dqe_desc_view
   import dqe_pkg::*;
#(
   parameter int unsigned EXT_LAYOUT = 0,
   parameter int unsigned AW         = 36,
   parameter int unsigned LEN_W      = 16
) (
   input  logic [WORD_W-1:0] ctl,
   input  logic [WORD_W-1:0] nxt,
   input  logic [WORD_W-1:0] bufp,
   input  logic [WORD_W-1:0] info,
   output logic              own,
   output logic              skip,
   output logic              irq,
   output logic [LEN_W-1:0]  xfer_len,
   output logic [AW-1:0]     next_ptr,
   output logic [AW-1:0]     buf_ptr,
   output logic [WORD_W-1:0] ctl_wb,
   output logic [WORD_W-1:0] info_wb
);
   localparam int unsigned HI_W = AW - WORD_W;

   logic [3:0] nxt_hi4;
   logic [3:0] buf_hi4;

   // the layout parameter picks where the high address nibbles sit (R11)
   if (EXT_LAYOUT != 0) begin : g_ext
      assign nxt_hi4 = ctl[31:28];
      assign buf_hi4 = ctl[27:24];
   end else begin : g_leg
      assign nxt_hi4 = ctl[23:20];
      assign buf_hi4 = ctl[19:16];
   end

   assign own      = ctl[OWN_BIT];
   assign skip     = ctl[SKIP_BIT];
   assign irq      = ctl[IRQ_BIT];
   assign xfer_len = info[LEN_W-1:0];
   assign next_ptr = {nxt_hi4[HI_W-1:0], nxt};
   assign buf_ptr  = {buf_hi4[HI_W-1:0], bufp};
   assign ctl_wb   = ctl & ~(WORD_W'(1) << OWN_BIT);
   assign info_wb  = {info[WORD_W-1:LEN_W], xfer_len};
endmodule

// File: rtl/dqe_beat_mover.sv
module dqe_beat_mover
   import dqe_pkg::*;
#(
   parameter int unsigned AW    = 36,
   parameter int unsigned LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [AW-1:0]     base_addr,
   input  logic [LEN_W-1:0]  nbytes,
   input  logic              stop_req,
   output logic              rd_req,
   output logic [AW-1:0]     rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              fin
);
   localparam int unsigned CNT_W = LEN_W - 1;

   mv_state_e         mst;
   logic [AW-1:0]     addr;
   logic [CNT_W-1:0]  left;
   logic [WORD_W-1:0] data_q;
   logic [LEN_W:0]    padded;

   assign padded = {1'b0, nbytes} + (LEN_W+1)'(3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst    <= MV_IDLE;
         addr   <= '0;
         left   <= '0;
         data_q <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (mst)
            MV_IDLE: if (go) begin
               addr <= base_addr;
               left <= padded[LEN_W:2];
               mst  <= MV_RD;
            end
            MV_RD:  mst <= MV_CAP;
            MV_CAP: begin
               data_q <= rd_data;
               mst    <= MV_PUSH;
            end
            MV_PUSH: if (tx_ready) begin
               addr <= addr + AW'(4);
               left <= left - CNT_W'(1);
               if (left == CNT_W'(1) || stop_req) begin
                  mst <= MV_IDLE;
                  fin <= 1'b1;
               end else begin
                  mst <= MV_RD;
               end
            end
            default: mst <= MV_IDLE;
         endcase
      end
   end

   assign rd_req   = (mst == MV_RD);
   assign rd_addr  = addr;
   assign tx_data  = data_q;
   assign tx_valid = (mst == MV_PUSH);
   assign tx_last  = (mst == MV_PUSH) && (left == CNT_W'(1));

   // R3: a presented beat waits for the sink without changing
   p_beat_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
   // R3: a new transfer is only launched into an idle mover
   p_go_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (mst == MV_IDLE));
endmodule

// File: rtl/dq_ring_engine.sv
module dq_ring_engine
   import dqe_pkg::*;
#(
   parameter int unsigned EXT_LAYOUT = 0,
   parameter int unsigned AW         = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_resume,
   input  logic [AW-1:0]     start_addr,
   output logic              q_active,
   output logic [AW-1:0]     cur_ptr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_last,
   input  logic              link_cserr,
   output logic              evt_done,
   output logic              evt_lenerr,
   output logic              evt_cserr
);
   localparam int unsigned LEN_W = len_width(EXT_LAYOUT);

   if (AW <= WORD_W || AW > WORD_W + 4) begin : g_bad_aw
      $error("AW must be between 33 and 36");
   end
   if (EXT_LAYOUT > 1) begin : g_bad_layout
      $error("EXT_LAYOUT must be 0 or 1");
   end

   eng_state_e        st;
   logic [1:0]        widx;
   logic [WORD_W-1:0] w_ctl, w_nxt, w_buf, w_info;
   logic              stop_q, err_q;

   logic              d_own, d_skip, d_irq;
   logic [LEN_W-1:0]  d_len;
   logic [AW-1:0]     d_next, d_buf;
   logic [WORD_W-1:0] d_ctl_wb, d_info_wb;

   logic              mv_go, mv_rd, mv_fin;
   logic [AW-1:0]     mv_addr;

   dqe_desc_view #(.EXT_LAYOUT(EXT_LAYOUT), .AW(AW), .LEN_W(LEN_W)) u_view (
      .ctl(w_ctl), .nxt(w_nxt), .bufp(w_buf), .info(w_info),
      .own(d_own), .skip(d_skip), .irq(d_irq), .xfer_len(d_len),
      .next_ptr(d_next), .buf_ptr(d_buf),
      .ctl_wb(d_ctl_wb), .info_wb(d_info_wb)
   );

   assign mv_go = (st == ST_EVAL) && d_own && !d_skip && (d_len != '0);

   dqe_beat_mover #(.AW(AW), .LEN_W(LEN_W)) u_mover (
      .clk(clk), .rst_n(rst_n), .go(mv_go), .base_addr(d_buf),
      .nbytes(d_len), .stop_req(err_q || stop_q),
      .rd_req(mv_rd), .rd_addr(mv_addr), .rd_data(mem_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
      .tx_ready(tx_ready), .fin(mv_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (st == ST_OFF)    stop_q <= 1'b0;
         else if (cmd_stop)   stop_q <= 1'b1;
         if (st != ST_MOVE)   err_q <= 1'b0;
         else if (link_cserr) err_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_OFF;
         widx    <= '0;
         cur_ptr <= '0;
         w_ctl   <= '0;
         w_nxt   <= '0;
         w_buf   <= '0;
         w_info  <= '0;
      end else begin
         case (st)
            ST_OFF: if (cmd_start) begin
               cur_ptr <= start_addr;
               widx    <= '0;
               st      <= ST_FREQ;
            end
            ST_FREQ: st <= stop_q ? ST_OFF : ST_FCAP;
            ST_FCAP: begin
               case (widx)
                  2'd0:    w_ctl  <= mem_rdata;
                  2'd1:    w_nxt  <= mem_rdata;
                  2'd2:    w_buf  <= mem_rdata;
                  default: w_info <= mem_rdata;
               endcase
               if (widx == 2'd3) begin
                  st <= ST_EVAL;
               end else begin
                  widx <= widx + 2'd1;
                  st   <= ST_FREQ;
               end
            end
            ST_EVAL: begin
               if (!d_own)             st <= ST_PARK;
               else if (d_skip)        st <= ST_WB_CTL;
               else if (d_len == '0)   st <= ST_HALT;
               else                    st <= ST_MOVE;
            end
            ST_MOVE: if (mv_fin) begin
               if (err_q)       st <= ST_HALT;
               else if (stop_q) st <= ST_OFF;
               else             st <= ST_WB_LEN;
            end
            ST_WB_LEN: st <= ST_WB_CTL;
            ST_WB_CTL: st <= ST_NEXT;
            ST_NEXT: begin
               cur_ptr <= d_next;
               widx    <= '0;
               st      <= ST_FREQ;
            end
            ST_PARK, ST_HALT: begin
               if (stop_q) begin
                  st <= ST_OFF;
               end else if (cmd_resume) begin
                  widx <= '0;
                  st   <= ST_FREQ;
               end
            end
            default: st <= ST_OFF;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = mv_addr;
      mem_wdata = d_ctl_wb;
      case (st)
         ST_FREQ: begin
            mem_req  = !stop_q;
            mem_addr = cur_ptr + AW'({widx, 2'b00});
         end
         ST_MOVE: mem_req = mv_rd;
         ST_WB_LEN: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_ptr + AW'(12);
            mem_wdata = d_info_wb;
         end
         ST_WB_CTL: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = cur_ptr;
         end
         default: ;
      endcase
   end

   assign q_active   = (st != ST_OFF);
   assign evt_done   = (st == ST_NEXT) && d_irq;
   assign evt_lenerr = (st == ST_EVAL) && d_own && !d_skip && (d_len == '0);
   assign evt_cserr  = (st == ST_MOVE) && mv_fin && err_q;

   // R1, R10: an inactive queue neither touches memory nor sends beats
   p_quiet_off_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !q_active |-> (!mem_req && !tx_valid));
   // R2: activation always starts from the programmed address
   p_start_ptr_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_active) |-> (cur_ptr == $past(start_addr)));
   // R6: completion follows the ownership-release write
   p_done_after_release_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |-> $past(mem_req && mem_we && !mem_wdata[OWN_BIT]));
   // R7, R9: a halted queue holds the failing descriptor pointer
   p_halt_holds_ptr_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HALT) |=> $stable(cur_ptr));
   // R6, R7, R9: at most one event per cycle
   p_one_event_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_done, evt_lenerr, evt_cserr}));
endmodule

// File: tb/dq_ring_engine_tb.sv
`timescale 1ns/1ps
module dq_ring_engine_tb;
   localparam int AW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          q_active;
   logic [AW-1:0] cur_ptr;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;
   logic [31:0]   tx_data;
   logic          tx_valid, tx_last, tx_ready;
   logic          link_cserr = 1'b0;
   logic          evt_done, evt_lenerr, evt_cserr;

   logic rdy_auto = 1'b1, rdy_man = 1'b0, rdy_tgl = 1'b0;
   assign tx_ready = rdy_auto ? rdy_tgl : rdy_man;

   always #2.5 clk = ~clk;
   always @(negedge clk) rdy_tgl <= ~rdy_tgl;

   dq_ring_engine #(.EXT_LAYOUT(1), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_resume(cmd_resume), .start_addr(start_addr), .q_active(q_active),
      .cur_ptr(cur_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
      .link_cserr(link_cserr), .evt_done(evt_done), .evt_lenerr(evt_lenerr),
      .evt_cserr(evt_cserr)
   );

   logic [31:0] mem [0:1023];
   always @(posedge clk) begin
      if (mem_req && mem_we) mem[mem_addr[11:2]] = mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
   end

   int n_chk = 0, n_fail = 0;
   int beats = 0, lasts = 0, done_cnt = 0, lenerr_cnt = 0, cserr_cnt = 0;
   int wr_cnt = 0, req_cnt = 0, hi_rd = 0;
   logic [31:0] exp_q [$];
   bit finished = 0;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: scoreboard pops expected beats as the design sends them
   always @(posedge clk) begin
      if (rst_n) begin
         if (tx_valid && tx_ready) begin
            beats++;
            if (tx_last) lasts++;
            if (exp_q.size() == 0) check("R3 unexpected beat", 64'(tx_data), 64'hFFFF_FFFF_FFFF);
            else check("R3 beat data", 64'(tx_data), 64'(exp_q.pop_front()));
         end
         if (evt_done) done_cnt++;
         if (evt_lenerr) lenerr_cnt++;
         if (evt_cserr) cserr_cnt++;
         if (mem_req) req_cnt++;
         if (mem_req && mem_we) wr_cnt++;
         if (mem_req && !mem_we && mem_addr[35:32] == 4'h2) hi_rd++;
      end
   end

   function automatic int dw(int k); return (32'h100 + 16 * k) >> 2; endfunction
   function automatic logic [31:0] pat(int k, int i); return 32'hA000_0000 + (k << 8) + i; endfunction

   // control word, extended layout: own bit0, skip bit2, irq bit7, next hi [31:28], buf hi [27:24]
   task automatic put_desc(int k, bit own, bit skip, bit irq, int nbytes, int nk,
                           logic [3:0] nhi, logic [3:0] bhi, logic [31:0] w3top);
      mem[dw(k)]     = {nhi, bhi, 16'h0, irq, 4'h0, skip, 1'b0, own};
      mem[dw(k) + 1] = 32'h100 + 16 * nk;
      mem[dw(k) + 2] = 32'h400 + 32'h40 * k;
      mem[dw(k) + 3] = w3top | 32'(nbytes);
   endtask

   task automatic fill_buf(int k, int n);
      for (int i = 0; i < n; i++) mem[((32'h400 + 32'h40 * k) >> 2) + i] = pat(k, i);
   endtask

   task automatic push_exp(int k, int first, int n);
      for (int i = first; i < first + n; i++) exp_q.push_back(pat(k, i));
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1; @(negedge clk); sig = 1'b0;
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] c0, c2, c3;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      settle(3);
      // R1 reset state
      check("R1 active", 64'(q_active), 0);
      check("R1 mem_req", 64'(mem_req), 0);
      check("R1 tx_valid", 64'(tx_valid), 0);
      check("R1 events", 64'({evt_done, evt_lenerr, evt_cserr}), 0);
      rst_n = 1'b1;
      settle(2);

      // chain: d0 (irq, 10 B), d1 (8 B, buffer hi nibble 2), d2 (irq, 4 B, next hi 1, w3 bit29)
      put_desc(0, 1, 0, 1, 10, 1, 4'h0, 4'h0, 32'h0);
      put_desc(1, 1, 0, 0, 8, 2, 4'h0, 4'h2, 32'h0);
      put_desc(2, 1, 0, 1, 4, 3, 4'h1, 4'h0, 32'h2000_0000);
      put_desc(3, 0, 0, 0, 0, 4, 4'h0, 4'h0, 32'h0);
      fill_buf(0, 3); fill_buf(1, 2); fill_buf(2, 1);
      push_exp(0, 0, 3); push_exp(1, 0, 2); push_exp(2, 0, 1);
      c0 = mem[dw(0)]; c2 = mem[dw(2)];
      start_addr = 36'h100;
      pulse(cmd_start);
      check("R2 start pointer", 64'(cur_ptr), 64'h100);
      check("R2 active after start", 64'(q_active), 1);
      for (int i = 0; i < 400 && cur_ptr != 36'h1_0000_0130; i++) @(negedge clk);
      settle(20);
      check("R3 all beats sent", 64'(exp_q.size()), 0);
      check("R3 beat count", 64'(beats), 6);
      check("R3 last flags", 64'(lasts), 3);
      check("R11 buffer hi nibble on bus", 64'(hi_rd), 2);
      check("R5 d0 word3", 64'(mem[dw(0) + 3]), 10);
      check("R5 d0 word0 released", 64'(mem[dw(0)]), 64'(c0 & ~32'h1));
      check("R11 d2 word3 upper flag kept", 64'(mem[dw(2) + 3]), 64'h2000_0004);
      check("R5 d2 word0 released", 64'(mem[dw(2)]), 64'(c2 & ~32'h1));
      check("R6 done count", 64'(done_cnt), 2);
      check("R12 R11 pointer with next hi", 64'(cur_ptr), 64'h1_0000_0130);
      check("R4 parked active", 64'(q_active), 1);
      check("R4 no write to unowned", 64'(wr_cnt), 6);

      // R2 start while active is ignored
      start_addr = 36'h200;
      pulse(cmd_start);
      settle(3);
      check("R2 start ignored while active", 64'(cur_ptr), 64'h1_0000_0130);

      // R7 zero length
      put_desc(3, 1, 0, 1, 0, 4, 4'h0, 4'h0, 32'h0);
      pulse(cmd_resume);
      settle(20);
      check("R7 lenerr event", 64'(lenerr_cnt), 1);
      check("R7 pointer held", 64'(cur_ptr), 64'h1_0000_0130);
      check("R7 no writes", 64'(wr_cnt), 6);
      check("R7 no beats", 64'(beats), 6);

      // R8 bypass
      put_desc(3, 1, 1, 1, 0, 4, 4'h0, 4'h0, 32'h0);
      put_desc(4, 0, 0, 1, 16, 5, 4'h0, 4'h0, 32'h0);
      c3 = mem[dw(3)];
      pulse(cmd_resume);
      settle(30);
      check("R8 skip word0", 64'(mem[dw(3)]), 64'(c3 & ~32'h1));
      check("R8 pointer advanced", 64'(cur_ptr), 64'h140);
      check("R8 no beats", 64'(beats), 6);
      check("R8 done for skipped irq", 64'(done_cnt), 3);
      check("R8 one write", 64'(wr_cnt), 7);

      // R9 checksum fault on first beat of d4
      put_desc(4, 1, 0, 1, 16, 5, 4'h0, 4'h0, 32'h0);
      put_desc(5, 0, 0, 1, 8, 6, 4'h0, 4'h0, 32'h0);
      fill_buf(4, 4);
      push_exp(4, 0, 1);
      rdy_auto = 1'b0; rdy_man = 1'b0;
      pulse(cmd_resume);
      for (int i = 0; i < 100 && !tx_valid; i++) @(negedge clk);
      link_cserr = 1'b1; @(negedge clk); link_cserr = 1'b0; rdy_man = 1'b1;
      settle(10);
      check("R9 cserr event", 64'(cserr_cnt), 1);
      check("R9 one beat before halt", 64'(beats), 7);
      check("R9 pointer held", 64'(cur_ptr), 64'h140);
      check("R9 no writeback", 64'(mem[dw(4)][0]), 1);
      rdy_auto = 1'b1;
      push_exp(4, 0, 4);
      pulse(cmd_resume);
      for (int i = 0; i < 200 && cur_ptr != 36'h150; i++) @(negedge clk);
      settle(20);
      check("R9 resend all beats", 64'(beats), 11);
      check("R9 scoreboard drained", 64'(exp_q.size()), 0);
      check("R9 done after resend", 64'(done_cnt), 4);

      // R10 stop during transfer
      put_desc(5, 1, 0, 1, 8, 6, 4'h0, 4'h0, 32'h0);
      put_desc(6, 0, 0, 0, 0, 7, 4'h0, 4'h0, 32'h0);
      fill_buf(5, 2);
      push_exp(5, 0, 1);
      rdy_auto = 1'b0; rdy_man = 1'b0;
      pulse(cmd_resume);
      for (int i = 0; i < 100 && !tx_valid; i++) @(negedge clk);
      cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0; rdy_man = 1'b1;
      settle(10);
      check("R10 inactive after stop", 64'(q_active), 0);
      check("R10 one beat before stop", 64'(beats), 12);
      check("R10 no writeback", 64'(mem[dw(5)][0]), 1);
      check("R10 pointer held", 64'(cur_ptr), 64'h150);
      begin
         int r0;
         r0 = req_cnt;
         pulse(cmd_resume);
         settle(10);
         check("R10 resume ignored inactive", 64'(q_active), 0);
         check("R10 no requests inactive", 64'(req_cnt - r0), 0);
      end

      // restart at d5, finish it, then stop while parked
      rdy_auto = 1'b1;
      push_exp(5, 0, 2);
      start_addr = 36'h150;
      pulse(cmd_start);
      for (int i = 0; i < 200 && cur_ptr != 36'h160; i++) @(negedge clk);
      settle(20);
      check("R12 advanced after restart", 64'(cur_ptr), 64'h160);
      check("R6 done count final", 64'(done_cnt), 5);
      check("R3 scoreboard drained", 64'(exp_q.size()), 0);
      pulse(cmd_stop);
      settle(4);
      check("R10 stop while parked", 64'(q_active), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule